// File: doc/BRIEF.md
# Sensor Frame and Line Valid Timing Generator

This block produces the line-valid and frame-valid strobes of an image sensor readout, together with a frame-start pulse and the row and column index of the pixel currently being output. It runs from a single pixel clock. A downstream data source uses `line_valid` as its pixel enable and the two indices to select which pixel to present. Every timing interval is derived from five configuration words: active row count, line width, horizontal blanking, vertical blanking and integration rows. Each interval follows a fixed offset equation.

Each frame is made of whole rows of `row_len = (cfg_width + cfg_hblank + 114) * 2` clocks. A row starts with its blanking interval and ends with its active pixels. Frame-valid opens a fixed lead before the first active pixel of the frame and closes a short, fixed tail after the last one. When the integration time in rows exceeds the natural frame length, the frame is stretched by adding blank rows. The configuration words are sampled only at frame boundaries, so changing them mid-frame never produces a malformed frame.

Top module: `fvlv_timing_gen`

## Requirements
- R1: In every active row, `line_valid` stays high for exactly `(cfg_width - 7) * 2` consecutive clocks.
- R2: Between two consecutive `line_valid` pulses of one frame, `line_valid` is low for exactly `(cfg_hblank + 121) * 2` clocks. The active pulses of successive rows are therefore spaced one `row_len` apart.
- R3: `frame_valid` rises `(cfg_hblank + 112) * 2` clocks before the first `line_valid` rise of the frame. It falls 14 clocks after the last `line_valid` fall, so it stays high for `(cfg_rows - 7) * row_len - 4` clocks.
- R4: When `cfg_integ <= cfg_rows + cfg_vblank + 2`, the frame period is `(cfg_rows + cfg_vblank + 2) * row_len` clocks.
- R5: Each frame holds exactly `cfg_rows - 7` `line_valid` pulses, and `line_valid` is never high while `frame_valid` is low.
- R6: When `cfg_integ > cfg_rows + cfg_vblank + 2`, the frame period is stretched to `(cfg_integ + 1) * row_len` clocks.
- R7: While `line_valid` is high, `pix_col` counts 0, 1, … up to `(cfg_width - 7) * 2 - 1` within the row, and `pix_row` gives the active row number, starting at 0. While `line_valid` is low, both indices are 0.
- R8: `frame_start` is a one-clock pulse issued once per frame, in the first clock of the frame period. `frame_valid` is low at that point.
- R9: Configuration inputs are sampled only at the frame boundary. A change applied mid-frame leaves the current frame untouched and fully governs the next one.
- R10: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | REG_W | Row count word (active rows = value - 7) |
| cfg_width | input | REG_W | Line width word (active clocks = (value - 7) * 2) |
| cfg_hblank | input | REG_W | Horizontal blanking word |
| cfg_vblank | input | REG_W | Vertical blanking word (extra rows) |
| cfg_integ | input | REG_W | Integration time in rows |
| line_valid | output | 1 | High during the active pixels of a row; serves as the pixel enable |
| frame_valid | output | 1 | High around the active rows of a frame |
| frame_start | output | 1 | One-clock pulse at the start of each frame |
| pix_col | output | REG_W+3 | Column index of the current pixel, 0 when idle |
| pix_row | output | REG_W+2 | Active row index of the current pixel, 0 when idle |

## Verification
The assertions assume the configuration is legal: `cfg_width` at least 8, `cfg_rows` at least 8 and `cfg_hblank` at least 9, so that every row has active pixels and the frame-valid lead fits inside the blanking interval. Every setting the stimulus drives stays inside that range. This includes the smallest legal frame, with one active row and a two-clock line. The stimulus changes the configuration only at a clock's falling edge, and only mid-frame or just after a frame start. This keeps the boundary sampling in a well-defined state.

// File: rtl/fvlv_pkg.sv
package fvlv_pkg;
  // Offsets of the timing equations; all lengths are in pixel clocks.
  localparam int unsigned LINE_OFS     = 7;    // active clocks = (width - LINE_OFS) * 2
  localparam int unsigned HBLANK_OFS   = 121;  // h-blank = (hblank + HBLANK_OFS) * 2
  localparam int unsigned LEAD_OFS     = 112;  // fv lead = (hblank + LEAD_OFS) * 2
  localparam int unsigned ROW_OFS      = 114;  // row = (width + hblank + ROW_OFS) * 2
  localparam int unsigned TAIL_CLKS    = 14;   // fv tail after last pixel
  localparam int unsigned ROWS_OFS     = 7;    // active rows = rows - ROWS_OFS
  localparam int unsigned FRAME_ROW_ADD = 2;   // frame rows = rows + vblank + FRAME_ROW_ADD

  typedef struct packed {
    logic [15:0] rows;
    logic [15:0] width;
    logic [15:0] hblank;
    logic [15:0] vblank;
    logic [15:0] integ;
  } cfg_words_t;
endpackage

// File: rtl/fvlv_shadow.sv
module fvlv_shadow #(
  parameter int REG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] in_rows,
  input  logic [REG_W-1:0] in_width,
  input  logic [REG_W-1:0] in_hblank,
  input  logic [REG_W-1:0] in_vblank,
  input  logic [REG_W-1:0] in_integ,
  output logic [REG_W-1:0] sh_rows,
  output logic [REG_W-1:0] sh_width,
  output logic [REG_W-1:0] sh_hblank,
  output logic [REG_W-1:0] sh_vblank,
  output logic [REG_W-1:0] sh_integ
);
  // Configuration is captured during reset and at each frame wrap only.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      sh_rows   <= in_rows;
      sh_width  <= in_width;
      sh_hblank <= in_hblank;
      sh_vblank <= in_vblank;
      sh_integ  <= in_integ;
    end
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(rst)) |->
      ($stable(sh_rows) && $stable(sh_width) && $stable(sh_hblank) &&
       $stable(sh_vblank) && $stable(sh_integ)));
endmodule

// File: rtl/fvlv_calc.sv
module fvlv_calc
  import fvlv_pkg::*;
#(
  parameter int REG_W = 12,
  parameter int COL_W = REG_W + 3,
  parameter int ROW_W = REG_W + 2
) (
  input  logic [REG_W-1:0] rows,
  input  logic [REG_W-1:0] width,
  input  logic [REG_W-1:0] hblank,
  input  logic [REG_W-1:0] vblank,
  input  logic [REG_W-1:0] integ,
  output logic [COL_W-1:0] act_len,
  output logic [COL_W-1:0] hblank_len,
  output logic [COL_W-1:0] fv_on_col,
  output logic [COL_W-1:0] row_len,
  output logic [ROW_W-1:0] act_rows,
  output logic [ROW_W-1:0] frame_rows
);
  logic [COL_W-1:0] w_c, h_c, lead_len;
  logic [ROW_W-1:0] r_r, v_r, i_r, base_rows;

  always_comb begin
    w_c = COL_W'(width);
    h_c = COL_W'(hblank);
    r_r = ROW_W'(rows);
    v_r = ROW_W'(vblank);
    i_r = ROW_W'(integ);

    act_len    = (w_c - COL_W'(LINE_OFS)) << 1;
    hblank_len = (h_c + COL_W'(HBLANK_OFS)) << 1;
    lead_len   = (h_c + COL_W'(LEAD_OFS)) << 1;
    row_len    = (w_c + h_c + COL_W'(ROW_OFS)) << 1;
    // Blank-first row: frame-valid opens this many clocks into row 0.
    fv_on_col  = hblank_len - lead_len;

    act_rows   = r_r - ROW_W'(ROWS_OFS);
    base_rows  = r_r + v_r + ROW_W'(FRAME_ROW_ADD);
    // Long integration stretches the frame to integ + 1 rows.
    frame_rows = (i_r > base_rows) ? (i_r + ROW_W'(1)) : base_rows;
  end
endmodule

// File: rtl/fvlv_counters.sv
module fvlv_counters #(
  parameter int COL_W = 15,
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] row_len,
  input  logic [ROW_W-1:0] frame_rows,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             wrap
);
  logic row_end;

  always_comb begin
    row_end = (col == row_len - COL_W'(1));
    wrap    = row_end && (row == frame_rows - ROW_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0;
      row <= '0;
    end else if (row_end) begin
      col <= '0;
      row <= wrap ? '0 : row + ROW_W'(1);
    end else begin
      col <= col + COL_W'(1);
    end
  end

  // R2
  col_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    col < row_len);
  // R4
  row_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    row < frame_rows);
endmodule

// File: rtl/fvlv_decode.sv
module fvlv_decode
  import fvlv_pkg::*;
#(
  parameter int COL_W = 15,
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] act_len,
  input  logic [COL_W-1:0] hblank_len,
  input  logic [COL_W-1:0] fv_on_col,
  input  logic [ROW_W-1:0] act_rows,
  output logic             lv,
  output logic             fv,
  output logic             fs,
  output logic [COL_W-1:0] px_col,
  output logic [ROW_W-1:0] px_row
);
  logic             in_act_row, lv_n, fv_n, fs_n;
  logic [COL_W-1:0] act_end;

  always_comb begin
    act_end    = hblank_len + act_len;
    in_act_row = (row < act_rows);
    lv_n       = in_act_row && (col >= hblank_len) && (col < act_end);
    fv_n       = ((row == '0) && (col >= fv_on_col)) ||
                 ((row != '0) && in_act_row) ||
                 ((row == act_rows) && (col < COL_W'(TAIL_CLKS)));
    fs_n       = (row == '0) && (col == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lv     <= 1'b0;
      fv     <= 1'b0;
      fs     <= 1'b0;
      px_col <= '0;
      px_row <= '0;
    end else begin
      lv     <= lv_n;
      fv     <= fv_n;
      fs     <= fs_n;
      px_col <= lv_n ? (col - hblank_len) : '0;
      px_row <= lv_n ? row : '0;
    end
  end

  // R5
  lv_inside_fv_chk: assert property (@(posedge clk) disable iff (rst)
    lv |-> fv);
  // R8
  fs_single_chk: assert property (@(posedge clk) disable iff (rst)
    fs |=> !fs);
  // R8
  fs_fv_low_chk: assert property (@(posedge clk) disable iff (rst)
    fs |-> !fv);
  // R7
  px_step_chk: assert property (@(posedge clk) disable iff (rst)
    (lv && $past(lv)) |-> ((px_col == $past(px_col) + COL_W'(1)) && $stable(px_row)));
  // R7
  px_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lv |-> ((px_col == '0) && (px_row == '0)));
endmodule

// File: rtl/fvlv_timing_gen.sv
module fvlv_timing_gen #(
  parameter int REG_W = 12,
  localparam int COL_W = REG_W + 3,
  localparam int ROW_W = REG_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] cfg_rows,
  input  logic [REG_W-1:0] cfg_width,
  input  logic [REG_W-1:0] cfg_hblank,
  input  logic [REG_W-1:0] cfg_vblank,
  input  logic [REG_W-1:0] cfg_integ,
  output logic             line_valid,
  output logic             frame_valid,
  output logic             frame_start,
  output logic [COL_W-1:0] pix_col,
  output logic [ROW_W-1:0] pix_row
);
  logic [REG_W-1:0] sh_rows, sh_width, sh_hblank, sh_vblank, sh_integ;
  logic [COL_W-1:0] act_len, hblank_len, fv_on_col, row_len, col;
  logic [ROW_W-1:0] act_rows, frame_rows, row;
  logic             wrap;

  fvlv_shadow #(.REG_W(REG_W)) u_shadow (
    .clk(clk), .rst(rst), .load(wrap),
    .in_rows(cfg_rows), .in_width(cfg_width), .in_hblank(cfg_hblank),
    .in_vblank(cfg_vblank), .in_integ(cfg_integ),
    .sh_rows(sh_rows), .sh_width(sh_width), .sh_hblank(sh_hblank),
    .sh_vblank(sh_vblank), .sh_integ(sh_integ)
  );

  fvlv_calc #(.REG_W(REG_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_calc (
    .rows(sh_rows), .width(sh_width), .hblank(sh_hblank),
    .vblank(sh_vblank), .integ(sh_integ),
    .act_len(act_len), .hblank_len(hblank_len), .fv_on_col(fv_on_col),
    .row_len(row_len), .act_rows(act_rows), .frame_rows(frame_rows)
  );

  fvlv_counters #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
    .clk(clk), .rst(rst), .row_len(row_len), .frame_rows(frame_rows),
    .col(col), .row(row), .wrap(wrap)
  );

  fvlv_decode #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst(rst), .col(col), .row(row),
    .act_len(act_len), .hblank_len(hblank_len), .fv_on_col(fv_on_col),
    .act_rows(act_rows),
    .lv(line_valid), .fv(frame_valid), .fs(frame_start),
    .px_col(pix_col), .px_row(pix_row)
  );
endmodule

// File: tb/fvlv_timing_gen_bench.sv
module fvlv_timing_gen_bench;
  localparam int REG_W = 12;
  localparam int COL_W = REG_W + 3;
  localparam int ROW_W = REG_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] cfg_rows, cfg_width, cfg_hblank, cfg_vblank, cfg_integ;
  logic line_valid, frame_valid, frame_start;
  logic [COL_W-1:0] pix_col;
  logic [ROW_W-1:0] pix_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fvlv_timing_gen #(.REG_W(REG_W)) u_fvlv_timing_gen (
    .clk(clk), .rst(rst),
    .cfg_rows(cfg_rows), .cfg_width(cfg_width), .cfg_hblank(cfg_hblank),
    .cfg_vblank(cfg_vblank), .cfg_integ(cfg_integ),
    .line_valid(line_valid), .frame_valid(frame_valid), .frame_start(frame_start),
    .pix_col(pix_col), .pix_row(pix_row)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, h, r, v, i);
    cfg_width = REG_W'(w); cfg_hblank = REG_W'(h); cfg_rows = REG_W'(r);
    cfg_vblank = REG_W'(v); cfg_integ = REG_W'(i);
  endtask

  // Measures one frame from frame_start to the next frame_start against the
  // equations for (w,h,r,v,i). Optionally rewrites the configuration at t==chg_t.
  task automatic measure(input string tag, input int w, h, r, v, i,
                         input bit sync_now, input int chg_t,
                         input int nw, nh, nr, nv, ni);
    int a_len, q_len, lead, rt, nrows, base, fv_len, act_rows;
    int t, len, fv_cnt, nlv, lv_rise, first_lv, last_fall, fv_rise, fv_fall;
    int bad_w, bad_g, bad_px;
    bit pfv, plv;
    a_len = (w - 7) * 2;
    q_len = (h + 121) * 2;
    lead  = (h + 112) * 2;
    rt    = (w + h + 114) * 2;
    base  = r + v + 2;
    nrows = (i > base) ? i + 1 : base;
    act_rows = r - 7;
    fv_len = act_rows * rt - (q_len - lead - 14);
    if (!(sync_now && frame_start)) begin
      do @(negedge clk); while (!frame_start);
    end
    chk(frame_valid == 1'b0, "R8", {tag, " fv low at frame_start"}, frame_valid, 0);
    t = 0; len = -1; fv_cnt = 0; nlv = 0; lv_rise = 0; first_lv = -1;
    last_fall = -1; fv_rise = -1; fv_fall = -1; bad_w = 0; bad_g = 0; bad_px = 0;
    pfv = 1'b0; plv = 1'b0;
    forever begin
      if (t == chg_t) set_cfg(nw, nh, nr, nv, ni);
      if (frame_valid) fv_cnt++;
      if (frame_valid && !pfv) fv_rise = t;
      if (!frame_valid && pfv) fv_fall = t;
      if (line_valid && !plv) begin
        nlv++;
        if (first_lv < 0) first_lv = t;
        else if (t - last_fall != q_len) bad_g++;
        lv_rise = t;
      end
      if (!line_valid && plv) begin
        if (t - lv_rise != a_len) bad_w++;
        last_fall = t;
      end
      if (line_valid) begin
        if (int'(pix_col) != t - lv_rise || int'(pix_row) != nlv - 1) bad_px++;
      end else if (pix_col != '0 || pix_row != '0) bad_px++;
      pfv = frame_valid; plv = line_valid;
      @(negedge clk);
      t++;
      if (frame_start) begin len = t; break; end
      if (t > 100000) break;
    end
    if (i > base) chk(len == nrows * rt, "R6", {tag, " stretched frame period"}, len, nrows * rt);
    else          chk(len == nrows * rt, "R4", {tag, " frame period"}, len, nrows * rt);
    chk(fv_cnt == fv_len, "R3", {tag, " fv high clocks"}, fv_cnt, fv_len);
    chk(nlv == act_rows, "R5", {tag, " lv pulses per frame"}, nlv, act_rows);
    chk(bad_w == 0, "R1", {tag, " lv widths off"}, bad_w, 0);
    chk(bad_g == 0, "R2", {tag, " lv gaps off"}, bad_g, 0);
    chk(first_lv - fv_rise == lead, "R3", {tag, " fv lead"}, first_lv - fv_rise, lead);
    chk(fv_fall - last_fall == 14, "R3", {tag, " fv tail"}, fv_fall - last_fall, 14);
    chk(bad_px == 0, "R7", {tag, " pixel index errors"}, bad_px, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!line_valid && !frame_valid && !frame_start && pix_col == '0 && pix_row == '0,
        "R10", "outputs during reset", {line_valid, frame_valid, frame_start}, 0);
    rst = 1'b0;
  endtask

  task automatic t_base;        // R1 R2 R3 R4 R5 R7 R8 baseline
    measure("base", 10, 9, 10, 1, 0, 1'b0, -1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_wide;
    set_cfg(20, 15, 12, 3, 5);
    measure("wide", 20, 15, 12, 3, 5, 1'b0, -1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_long_integ;  // R6
    set_cfg(10, 9, 10, 1, 20);
    measure("long", 10, 9, 10, 1, 20, 1'b0, -1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_integ_edge;  // R4 boundary: integ equals natural row count
    set_cfg(10, 9, 10, 1, 13);
    measure("edge", 10, 9, 10, 1, 13, 1'b0, -1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_min_frame;   // one active row, two-clock line
    set_cfg(8, 9, 8, 0, 0);
    measure("min", 8, 9, 8, 0, 0, 1'b0, -1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mid_change;  // R9: change mid-frame, next frame follows it
    set_cfg(10, 9, 10, 1, 0);
    measure("r9_old", 10, 9, 10, 1, 0, 1'b0, 500, 14, 10, 9, 2, 0);
    measure("r9_new", 14, 10, 9, 2, 0, 1'b1, -1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    set_cfg(10, 9, 10, 1, 0);
    t_reset();
    t_base();
    t_wide();
    t_long_integ();
    t_integ_edge();
    t_min_frame();
    t_mid_change();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule